// File: doc/BRIEF.md
# Programmable System Clock Enable Divider Tree

This block turns one source clock into three related clock enables: a core enable, a bus enable and a peripheral enable. It is built for a chip that runs from a single master clock. The PLL clock and the crystal clock reach the block as single-cycle tick strobes in that master domain. Each output is a one-cycle enable pulse. Its spacing, counted in ticks of the selected source, is set by division codes taken from a 32-bit configuration word.

The core and bus enables are each divided from the selected source. The peripheral enable is divided from the bus enable, so its period is the product of the bus and peripheral divisors. One bit of the word chooses the source. When the bit is clear, the crystal ticks feed the tree. When it is set, the PLL ticks feed it.

A new word is captured on a load strobe. Each divide stage keeps its present divisor and holds the new one as pending. It switches over only at its next terminal count, so no pulse period is ever cut short. Each stage is a two-state machine:
- ST_RUN: no divisor is waiting.
- ST_PEND: a divisor is waiting.

The transitions are:
- ST_RUN to ST_PEND on a load away from the terminal count.
- ST_PEND to ST_RUN at the terminal count.
- A load that coincides with a terminal count is adopted at once and leaves the stage in ST_RUN.

Top module: `clkdiv_tree`

## Requirements
- R1: After reset every divisor is 1, every counter is cleared and the crystal ticks are selected. Each crystal tick then produces a pulse on all three outputs.
- R2: The core divisor code in word bits 27:25 selects the divisor as follows: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 16. Codes 5, 6 and 7 give 1.
- R3: The bus divisor code in word bits 22:20 selects, for codes 0 to 7, the divisors 1, 2, 4, 5, 6, 8, 16 and 32.
- R4: The peripheral divisor code in word bits 19:18 selects, for codes 0 to 3, the divisors 1, 2, 4 and 8. The peripheral enable is counted on bus enable pulses, so its spacing is the bus divisor times the peripheral divisor. A peripheral pulse occurs only together with a bus pulse.
- R5: Word bit 23 selects the source. With the bit at 0 the crystal ticks feed the tree; with the bit at 1 the PLL ticks feed it. The selection changes on the clock edge that captures the load.
- R6: Every output pulse lasts one clock cycle and occurs only in a cycle in which the selected source tick is present.
- R7: A newly loaded divisor takes effect only at the stage's next terminal count. The pulse period that is running when the load arrives completes with the old divisor.
- R8: Changes on the configuration word while the load strobe is low have no effect on divisors or source selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_tick_i | input | 1 | One-cycle strobe per PLL clock period |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal clock period |
| cfg_word_i | input | 32 | Configuration word (divisor codes and source bit) |
| cfg_load_i | input | 1 | Captures cfg_word_i on this cycle |
| core_en_o | output | 1 | Core clock enable pulse |
| bus_en_o | output | 1 | Bus clock enable pulse |
| per_en_o | output | 1 | Peripheral clock enable pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit word and 6-bit divide counters. With these, the largest period is 256 source ticks. That is short enough to sweep all 64 pairings of core and bus codes and all 32 pairings of bus and peripheral codes, and to measure the settled spacing of every output for each pairing.

The PLL strobe is kept high on every cycle and the crystal strobe comes every third cycle. The spacing is recorded both in source ticks and in master cycles, which shows which source is actually in use. Directed sequences load a new divisor in the middle of a long period to confirm that the old period completes. They also change the word without a load strobe to confirm that nothing changes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned CFG_W    = 32;
    localparam int unsigned DIV_W    = 6;
    localparam int unsigned CORE_LSB = 25;
    localparam int unsigned CORE_CW  = 3;
    localparam int unsigned SRC_BIT  = 23;
    localparam int unsigned BUS_LSB  = 20;
    localparam int unsigned BUS_CW   = 3;
    localparam int unsigned PER_LSB  = 18;
    localparam int unsigned PER_CW   = 2;

    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } stage_st_e;

    function automatic div_t core_div_f(input logic [CORE_CW-1:0] code);
        div_t d;
        case (code)
            3'd1:    d = div_t'(2);
            3'd2:    d = div_t'(4);
            3'd3:    d = div_t'(8);
            3'd4:    d = div_t'(16);
            default: d = div_t'(1);
        endcase
        return d;
    endfunction

    function automatic div_t bus_div_f(input logic [BUS_CW-1:0] code);
        div_t d;
        case (code)
            3'd0:    d = div_t'(1);
            3'd1:    d = div_t'(2);
            3'd2:    d = div_t'(4);
            3'd3:    d = div_t'(5);
            3'd4:    d = div_t'(6);
            3'd5:    d = div_t'(8);
            3'd6:    d = div_t'(16);
            default: d = div_t'(32);
        endcase
        return d;
    endfunction

    function automatic div_t per_div_f(input logic [PER_CW-1:0] code);
        return div_t'(1) << code;
    endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
(
    input  logic [CFG_W-1:0] word_i,
    output div_t             core_div_o,
    output div_t             bus_div_o,
    output div_t             per_div_o,
    output logic             pll_sel_o
);

    logic unused_bits;

    always_comb begin
        core_div_o = core_div_f(word_i[CORE_LSB +: CORE_CW]);
        bus_div_o  = bus_div_f(word_i[BUS_LSB +: BUS_CW]);
        per_div_o  = per_div_f(word_i[PER_LSB +: PER_CW]);
        pll_sel_o  = word_i[SRC_BIT];
    end

    assign unused_bits = ^{word_i[CFG_W-1:CORE_LSB+CORE_CW],
                           word_i[SRC_BIT+1],
                           word_i[PER_LSB-1:0]};

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
    import clkdiv_pkg::*;
#(
    parameter int unsigned W = DIV_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] div_i,
    output logic         pulse_o
);

    stage_st_e    st_q, st_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] pend_q;
    logic         at_end;

    // Terminal count: last tick of the running period.
    assign at_end = tick_i && (cnt_q == cur_q - W'(1));

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (load_i && !at_end) st_d = ST_PEND;
            ST_PEND: if (at_end)            st_d = ST_RUN;
        endcase
    end

    // Counter and divisor registers.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            cur_q  <= W'(1);
            pend_q <= W'(1);
        end else begin
            if (load_i) begin
                pend_q <= div_i;
            end
            if (tick_i) begin
                cnt_q <= at_end ? '0 : cnt_q + W'(1);
            end
            if (at_end) begin
                if (load_i) begin
                    cur_q <= div_i;
                end else if (st_q == ST_PEND) begin
                    cur_q <= pend_q;
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        pulse_o = at_end;
    end

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
    import clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pll_tick_i,
    input  logic             xtal_tick_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic             cfg_load_i,
    output logic             core_en_o,
    output logic             bus_en_o,
    output logic             per_en_o
);

    localparam int unsigned N_SRC_STAGES = 2;

    div_t                    core_div, bus_div, per_div;
    logic                    new_sel;
    logic                    pll_sel_q;
    logic                    src_tick;
    div_t                    src_div [N_SRC_STAGES];
    logic [N_SRC_STAGES-1:0] src_pulse;

    clkdiv_decode u_dec (
        .word_i     (cfg_word_i),
        .core_div_o (core_div),
        .bus_div_o  (bus_div),
        .per_div_o  (per_div),
        .pll_sel_o  (new_sel)
    );

    // Source selection changes on the capturing edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pll_sel_q <= 1'b0;
        end else if (cfg_load_i) begin
            pll_sel_q <= new_sel;
        end
    end

    assign src_tick   = pll_sel_q ? pll_tick_i : xtal_tick_i;
    assign src_div[0] = core_div;
    assign src_div[1] = bus_div;

    // Stages counted directly on the selected source.
    for (genvar g = 0; g < N_SRC_STAGES; g++) begin : g_src_stage
        clkdiv_stage #(.W(DIV_W)) u_stage (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (src_tick),
            .load_i  (cfg_load_i),
            .div_i   (src_div[g]),
            .pulse_o (src_pulse[g])
        );
    end

    // Peripheral stage counted on bus pulses.
    clkdiv_stage #(.W(DIV_W)) u_per_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (src_pulse[1]),
        .load_i  (cfg_load_i),
        .div_i   (per_div),
        .pulse_o (per_en_o)
    );

    assign core_en_o = src_pulse[0];
    assign bus_en_o  = src_pulse[1];

endmodule

// File: rtl/clkdiv_tree_chk.sv
module clkdiv_tree_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic load_i,
    input logic sel_bit_i,
    input logic src_tick_i,
    input logic pll_sel_i,
    input logic core_en_i,
    input logic bus_en_i,
    input logic per_en_i
);

    // R6
    core_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_en_i |-> src_tick_i);

    // R6
    bus_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_en_i |-> src_tick_i);

    // R4
    per_within_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        per_en_i |-> bus_en_i);

    // R8
    src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(pll_sel_i));

    // R5
    src_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (pll_sel_i == $past(sel_bit_i)));

endmodule

bind clkdiv_tree clkdiv_tree_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_load_i),
    .sel_bit_i  (cfg_word_i[23]),
    .src_tick_i (src_tick),
    .pll_sel_i  (pll_sel_q),
    .core_en_i  (core_en_o),
    .bus_en_i   (bus_en_o),
    .per_en_i   (per_en_o)
);

// File: tb/clkdiv_tree_tb.sv
`timescale 1ns/1ps
module clkdiv_tree_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pll_tick = 1'b1;
    logic        xtal_tick = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        cfg_load = 1'b0;
    logic        core_en, bus_en, per_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit exp_pll = 0;

    int tk [3];
    int cy [3];
    int ltk [3];
    int lcy [3];
    int np [3];
    int stray = 0;

    always #2.5 clk = ~clk;

    clkdiv_tree u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pll_tick_i  (pll_tick),
        .xtal_tick_i (xtal_tick),
        .cfg_word_i  (cfg_word),
        .cfg_load_i  (cfg_load),
        .core_en_o   (core_en),
        .bus_en_o    (bus_en),
        .per_en_o    (per_en)
    );

    // Crystal strobe every third cycle.
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #1;
            ph = (ph == 2) ? 0 : ph + 1;
            xtal_tick = (ph == 0);
        end
    end

    // Spacing monitor, sampled away from the active edge.
    always @(negedge clk) begin
        logic       cur_tick;
        logic [2:0] en;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                tk[i] = 0; cy[i] = 0; ltk[i] = 0; lcy[i] = 0; np[i] = 0;
            end
        end else begin
            cur_tick = exp_pll ? pll_tick : xtal_tick;
            en = {per_en, bus_en, core_en};
            for (int i = 0; i < 3; i++) begin
                cy[i]++;
                if (cur_tick) tk[i]++;
                if (en[i]) begin
                    ltk[i] = tk[i]; lcy[i] = cy[i];
                    tk[i] = 0; cy[i] = 0; np[i]++;
                    if (!cur_tick) stray++;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit pll, input int c, input int b, input int p);
        logic [31:0] w = '0;
        w[23]    = pll;
        w[27:25] = c[2:0];
        w[22:20] = b[2:0];
        w[19:18] = p[1:0];
        return w;
    endfunction

    function automatic int core_exp(input int c);
        return (c < 5) ? (1 << c) : 1;
    endfunction

    function automatic int bus_exp(input int b);
        if (b < 3) return 1 << b;
        if (b < 5) return b + 2;
        return 1 << (b - 2);
    endfunction

    task automatic load(input logic [31:0] w);
        @(posedge clk);
        #1;
        cfg_word = w;
        cfg_load = 1'b1;
        @(posedge clk);
        exp_pll = w[23];
        #1;
        cfg_load = 1'b0;
    endtask

    task automatic settle(input int n);
        int c0 = np[0];
        int c1 = np[1];
        int c2 = np[2];
        while (np[0] < c0 + n || np[1] < c1 + n || np[2] < c2 + n) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, divide by 1 on crystal ticks
        settle(2);
        for (int i = 0; i < 3; i++) begin
            chk("R1 ticks", ltk[i], 1);
            chk("R1 cycles", lcy[i], 3);
        end

        // R2 and R3: every core and bus code, PLL source
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 8; b++) begin
                load(mk(1, c, b, 0));
                settle(3);
                chk("R2 core", ltk[0], core_exp(c));
                chk("R3 bus", ltk[1], bus_exp(b));
                chk("R4 per", ltk[2], bus_exp(b));
            end
        end

        // R4: peripheral cascades from bus
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 4; p++) begin
                load(mk(1, 0, b, p));
                settle(3);
                chk("R4 per", ltk[2], bus_exp(b) * (1 << p));
                chk("R4 per cycles", lcy[2], bus_exp(b) * (1 << p));
            end
        end

        // R5: crystal source, then back to PLL
        load(mk(0, 2, 3, 1));
        settle(3);
        chk("R5 core xtal", lcy[0], 12);
        chk("R5 bus xtal", lcy[1], 15);
        chk("R5 per xtal", lcy[2], 30);
        chk("R5 per ticks", ltk[2], 10);
        load(mk(1, 2, 3, 1));
        settle(3);
        chk("R5 core pll", lcy[0], 4);
        chk("R5 per pll", lcy[2], 10);

        // R8: word change without strobe is ignored
        load(mk(1, 3, 0, 0));
        settle(3);
        @(posedge clk);
        #1 cfg_word = mk(0, 0, 7, 3);
        settle(3);
        chk("R8 core", lcy[0], 8);
        chk("R8 bus", lcy[1], 1);
        chk("R8 per", lcy[2], 1);

        // R7: running period completes with old divisor
        load(mk(1, 4, 0, 0));
        settle(2);
        k = np[0];
        while (np[0] == k) @(posedge clk);
        repeat (3) @(posedge clk);
        load(mk(1, 0, 0, 0));
        k = np[0];
        while (np[0] == k) @(posedge clk);
        chk("R7 old period", ltk[0], 16);
        k = np[0];
        while (np[0] == k) @(posedge clk);
        chk("R7 new period", ltk[0], 1);

        // R6: no pulse without a source tick
        chk("R6 stray pulses", stray, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule